// File: doc/BRIEF.md
# Barrel shifter with carry-out

This block is the operand shifter of a 32-bit RISC datapath. It takes one data word, a three-bit shift kind, a shift count and the current carry flag. It returns the shifted word together with the carry bit that the flag logic should capture. Five kinds are supported: shift left, logical shift right, arithmetic shift right, rotate right, and a one-bit rotate right through the carry flag.

The count may come from an instruction immediate or from a register. Only its least significant byte is used, so a register value can be passed in unmasked. The carry-out follows the architectural rules at each count boundary: zero, 1 to 31, exactly 32, and above 32. One optional output register, selected by a parameter and enabled by default, breaks the timing path. With it enabled, results appear one clock edge after the inputs are sampled.

Top module: `bshift_core`

## Requirements
- R1: The kind code is 0 = shift left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate right by one through carry. Codes 5, 6 and 7 return the operand unchanged, with carry-out equal to carry-in.
- R2: Only bits 7:0 of `amount_i` form the count n. Bits 31:8 have no effect on either output.
- R3: With n = 0 and kind 0 to 3, the result equals the operand and the carry-out equals the carry-in.
- R4: A left shift by n in 1..32 fills with zeros from bit 0, and the carry-out is operand bit 32-n. At n = 32 the result is 0 and the carry-out is operand bit 0.
- R5: A left shift or a logical right shift by n above 32 gives a result of 0 and a carry-out of 0.
- R6: A logical right shift by n in 1..32 fills with zeros from bit 31, and the carry-out is operand bit n-1.
- R7: An arithmetic right shift by n in 1..32 fills with copies of operand bit 31, and the carry-out is operand bit n-1. For n above 32, every result bit and the carry-out equal operand bit 31.
- R8: A rotate right by nonzero n rotates by n modulo 32, and the carry-out is bit 31 of the rotated word. A nonzero multiple of 32 leaves the word unchanged.
- R9: The rotate through carry ignores n. It shifts right by one, puts the carry-in into bit 31, and gives operand bit 0 as the carry-out.
- R10: With the output register enabled, the outputs reflect the inputs sampled at the previous rising clock edge. While reset is low, the result and the carry-out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opnd_i | input | 32 | Data word to shift |
| kind_i | input | 3 | Shift kind code (see R1) |
| amount_i | input | 32 | Shift count; only bits 7:0 are used |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
Both outputs are due exactly one rising edge after the inputs that produced them, because only the output register sits between the inputs and the outputs. The bench changes inputs on the falling edge and compares on the next falling edge. Each comparison therefore sees the register loaded from precisely that vector and nothing newer. The reset value is checked while reset is still held, before the first vector. The properties state each boundary rule as a one-cycle implication from the sampled inputs to the registered outputs.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } sh_kind_e;

  // classification of the effective count against the word width
  typedef struct packed {
    logic zero;   // count is 0
    logic exact;  // count equals the word width
    logic over;   // count exceeds the word width
  } amt_cls_t;

endpackage

// File: rtl/bsh_amount_decode.sv
module bsh_amount_decode #(
  parameter int W        = 32,
  parameter int AMT_IN_W = 32,
  parameter int CNT_W    = 8
) (
  input  logic [AMT_IN_W-1:0] amt_i,
  output logic [CNT_W-1:0]    cnt_o,
  output bsh_pkg::amt_cls_t   cls_o
);
  localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(W);

  // high bits of the count input play no part in the shift
  logic hi_unused;
  assign hi_unused = ^amt_i[AMT_IN_W-1:CNT_W];

  assign cnt_o       = amt_i[CNT_W-1:0];
  assign cls_o.zero  = (cnt_o == '0);
  assign cls_o.exact = (cnt_o == WIDTH_CNT);
  assign cls_o.over  = (cnt_o > WIDTH_CNT);
endmodule

// File: rtl/bsh_datapath.sv
module bsh_datapath #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]      opnd_i,
  input  logic [2:0]        kind_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  bsh_pkg::amt_cls_t cls_i,
  input  logic              carry_i,
  output logic [W:0]        res_o      // {carry, word}
);
  import bsh_pkg::*;
  localparam int RB = $clog2(W);

  // left shift for counts 1..W: carry is the last bit pushed out of the top
  function automatic logic [W:0] f_left(input logic [W-1:0] v, input logic [CNT_W-1:0] n);
    logic [2*W:0] t;
    t = {{(W+1){1'b0}}, v} << n;
    return t[W:0];
  endfunction

  // right shift for counts 1..W with a chosen fill bit; a guard bit below
  // bit 0 catches the last bit shifted out
  function automatic logic [W:0] f_right(input logic [W-1:0] v, input logic fill,
                                         input logic [CNT_W-1:0] n);
    logic [2*W:0] t;
    t = {{W{fill}}, v, 1'b0} >> n;
    return {t[0], t[W:1]};
  endfunction

  // rotation by r modulo W; carry is the new top bit
  function automatic logic [W:0] f_rot(input logic [W-1:0] v, input logic [RB-1:0] r);
    logic [2*W-1:0] t;
    t = {v, v} >> r;
    return {t[W-1], t[W-1:0]};
  endfunction

  // one-bit rotation through the carry flag
  function automatic logic [W:0] f_rrx(input logic [W-1:0] v, input logic c);
    return {v[0], c, v[W-1:1]};
  endfunction

  logic sgn;
  assign sgn = opnd_i[W-1];

  always_comb begin
    res_o = {carry_i, opnd_i};
    if (kind_i == SH_RRX) begin
      res_o = f_rrx(opnd_i, carry_i);
    end else if (kind_i > SH_RRX) begin
      res_o = {carry_i, opnd_i};
    end else if (cls_i.zero) begin
      res_o = {carry_i, opnd_i};
    end else begin
      unique case (kind_i)
        SH_LSL:  res_o = cls_i.over ? '0 : f_left(opnd_i, cnt_i);
        SH_LSR:  res_o = cls_i.over ? '0 : f_right(opnd_i, 1'b0, cnt_i);
        SH_ASR:  res_o = cls_i.over ? {(W+1){sgn}} : f_right(opnd_i, sgn, cnt_i);
        SH_ROR:  res_o = f_rot(opnd_i, cnt_i[RB-1:0]);
        default: res_o = {carry_i, opnd_i};
      endcase
    end
  end
endmodule

// File: rtl/bsh_outreg.sv
module bsh_outreg #(
  parameter int W       = 33,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end else begin : g_wire
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
  parameter int W        = 32,
  parameter int AMT_IN_W = 32,
  parameter int CNT_W    = 8,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0]        opnd_i,
  input  logic [2:0]          kind_i,
  input  logic [AMT_IN_W-1:0] amount_i,
  input  logic                carry_i,
  output logic [W-1:0]        result_o,
  output logic                carry_o
);
  logic [CNT_W-1:0]  cnt;
  bsh_pkg::amt_cls_t cls;
  logic [W:0]        comb_res;
  logic [W:0]        reg_res;

  // named events for the property checker
  logic amt_zero;
  logic amt_over;

  bsh_amount_decode #(.W(W), .AMT_IN_W(AMT_IN_W), .CNT_W(CNT_W)) u_dec (
    .amt_i (amount_i),
    .cnt_o (cnt),
    .cls_o (cls)
  );

  assign amt_zero = cls.zero;
  assign amt_over = cls.over;

  bsh_datapath #(.W(W), .CNT_W(CNT_W)) u_dp (
    .opnd_i  (opnd_i),
    .kind_i  (kind_i),
    .cnt_i   (cnt),
    .cls_i   (cls),
    .carry_i (carry_i),
    .res_o   (comb_res)
  );

  bsh_outreg #(.W(W+1), .REG_OUT(REG_OUT)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (comb_res),
    .q_o    (reg_res)
  );

  assign result_o = reg_res[W-1:0];
  assign carry_o  = reg_res[W];
endmodule

// File: rtl/bsh_props.sv
module bsh_props #(
  parameter int W        = 32,
  parameter int AMT_IN_W = 32,
  parameter bit REG_OUT  = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [W-1:0]        opnd_i,
  input logic [2:0]          kind_i,
  input logic [AMT_IN_W-1:0] amount_i,
  input logic                carry_i,
  input logic [W-1:0]        result_o,
  input logic                carry_o,
  input logic                amt_zero,
  input logic                amt_over
);
  generate
    if (REG_OUT) begin : g_chk
      // R1: undefined kind codes leave word and carry as they were
      a_r1_spare_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i > 3'd4) |=> (result_o == $past(opnd_i) && carry_o == $past(carry_i)));

      // R3: zero count passes through for every kind except the carry rotate
      a_r3_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (amt_zero && kind_i < 3'd4) |=> (result_o == $past(opnd_i) && carry_o == $past(carry_i)));

      // R5: logical shifts past the width clear both outputs
      a_r5_over_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (amt_over && (kind_i == 3'd0 || kind_i == 3'd1)) |=> (result_o == '0 && !carry_o));

      // R7: arithmetic shift past the width saturates to the sign
      a_r7_asr_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (amt_over && kind_i == 3'd2) |=>
          (result_o == {W{$past(opnd_i[W-1])}} && carry_o == $past(opnd_i[W-1])));

      // R9: carry rotate moves carry into the top and bit 0 out
      a_r9_rrx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == 3'd4) |=>
          (result_o == {$past(carry_i), $past(opnd_i[W-1:1])} && carry_o == $past(opnd_i[0])));

      // R8: rotation keeps the number of ones
      a_r8_rot_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind_i == 3'd3) |=> ($countones(result_o) == $countones($past(opnd_i))));
    end
  endgenerate
endmodule

bind bshift_core bsh_props #(.W(W), .AMT_IN_W(AMT_IN_W), .REG_OUT(REG_OUT)) u_props (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opnd_i   (opnd_i),
  .kind_i   (kind_i),
  .amount_i (amount_i),
  .carry_i  (carry_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .amt_zero (amt_zero),
  .amt_over (amt_over)
);

// File: tb/test_bshift_core.sv
module test_bshift_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd = 32'h0;
  logic [2:0]  kind = 3'd0;
  logic [31:0] amount = 32'h0;
  logic        cin = 1'b0;
  logic [31:0] result;
  logic        cout;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bshift_core i_bshift_core (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .opnd_i   (opnd),
    .kind_i   (kind),
    .amount_i (amount),
    .carry_i  (cin),
    .result_o (result),
    .carry_o  (cout)
  );

  // bit-by-bit reference, written from the requirements
  task automatic model(input int k, input int n, input logic [31:0] v, input logic c,
                       output logic [31:0] r, output logic co);
    logic fill;
    r = v; co = c;
    if (k == 4) begin
      for (int i = 0; i < 32; i++) r[i] = (i == 31) ? c : v[i+1];
      co = v[0];
    end else if (k > 4 || n == 0) begin
      r = v; co = c;
    end else if (k == 0) begin
      for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? v[i-n] : 1'b0;
      co = (n <= 32) ? v[32-n] : 1'b0;
    end else if (k == 1 || k == 2) begin
      fill = (k == 2) ? v[31] : 1'b0;
      for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : fill;
      co = (n <= 32) ? v[n-1] : fill;
    end else begin
      for (int i = 0; i < 32; i++) r[i] = v[(i + (n % 32)) % 32];
      co = r[31];
    end
  endtask

  function automatic string tag_of(input int k, input int n);
    if (k > 4)  return "R1";
    if (k == 4) return "R9";
    if (n == 0) return "R3";
    if (k == 0) return (n > 32) ? "R5" : "R4";
    if (k == 1) return (n > 32) ? "R5" : "R6";
    if (k == 2) return "R7";
    return "R8";
  endfunction

  task automatic apply(input int k, input int n, input logic [23:0] hi,
                       input logic [31:0] v, input logic c);
    logic [31:0] er;
    logic        ec;
    string       tg;
    kind = 3'(k); amount = {hi, 8'(n)}; opnd = v; cin = c;
    model(k, n, v, c, er, ec);
    tg = tag_of(k, n);
    if (hi != 0) tg = {tg, "+R2"};
    @(negedge clk);  // one register stage: due after the intervening rising edge (R10)
    n_vec++;
    if (result !== er || cout !== ec) begin
      n_fail++;
      $display("FAIL %s kind=%0d n=%0d op=%h cin=%0b: actual %h/%0b expected %h/%0b",
               tg, k, n, v, c, result, cout, er, ec);
    end
  endtask

  initial begin
    logic [31:0] pats [6];
    int amts [46];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hDEAD_BEEF;
    pats[3] = 32'h0000_0000; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h1234_5679;
    for (int i = 0; i <= 40; i++) amts[i] = i;
    amts[41] = 63; amts[42] = 64; amts[43] = 100; amts[44] = 128; amts[45] = 255;

    // R10: reset value while reset is held
    opnd = 32'hFFFF_FFFF; kind = 3'd4; cin = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (result !== 32'h0 || cout !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: actual %h/%0b expected 00000000/0", result, cout);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 46; a++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++)
            apply(k, amts[a], ((a + p + c) % 2 == 1) ? 24'h5A3C01 : 24'h0, pats[p], 1'(c));

    // R2: upper bits alone set, low byte zero: must act as count 0
    apply(0, 0, 24'hFFFFFF, 32'hCAFE_F00D, 1'b1);
    apply(1, 0, 24'h000100, 32'hCAFE_F00D, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule